// File: doc/BRIEF.md
# Immediate Prefix Operand Generator

This block lives in the decode stage of a small 16-bit RISC core. It produces the 16-bit immediate operand for the instruction in the instruction register. Most register-immediate instructions hold only a 4-bit constant in their low nibble. A dedicated prefix instruction (opcode 0xD) can carry a 12-bit field, and that field becomes the upper twelve bits of the operand of the next instruction that decode consumes. The block keeps this field, and a flag saying that it is waiting, between instructions.

The block also forms the absolute target of the call instruction (opcode 0xC), which is its 12-bit field shifted left by four. It raises an interrupt-inhibit signal whenever a prefix is in flight, so that interrupt insertion can never come between a prefix and the instruction that uses it. `dec_valid` marks the cycle in which decode consumes the instruction register. `annul` marks that instruction as squashed, for example in the shadow of a taken branch.

Top module: `imm_prefix_gen`

## Requirements
- R1: A synchronous active-high `rst` clears the pending-prefix state, so `prefix_pending` reads 0 in the cycle after any clock edge at which `rst` was high.
- R2: With no prefix pending, opcodes 0x2, 0x5, 0x6, 0x8, 0x9 and 0xA produce `imm_out` equal to `ir[3:0]` sign-extended to 16 bits.
- R3: With no prefix pending, opcode 0x4 (logic and shift immediates) produces `imm_out` equal to `ir[3:0]` zero-extended to 16 bits.
- R4: A consumed (`dec_valid`=1), non-annulled instruction with opcode 0xD sets `prefix_pending` from the next cycle and stores its field `ir[11:0]`.
- R5: While a prefix is pending, any opcode listed in R2 or R3 produces `imm_out` = {stored field, `ir[3:0]`}.
- R6: A consumed, non-annulled instruction whose opcode is not 0xD clears `prefix_pending` from the next cycle. A second prefix that follows a prefix replaces the stored field and leaves the flag set.
- R7: An annulled instruction leaves the pending state unchanged. An annulled prefix does not set the flag or alter the stored field, and an annulled consumer does not clear the flag.
- R8: While `dec_valid` is 0, the pending flag and the stored field hold their values.
- R9: `int_inhibit` is 1 whenever `prefix_pending` is 1, and also in any cycle where `dec_valid`=1, `annul`=0 and the opcode is 0xD. It is 0 otherwise.
- R10: `call_target` always equals {`ir[11:0]`, 4'b0000}.
- R11: Opcodes 0x0, 0x1, 0x3, 0x7, 0xB, 0xC, 0xD, 0xE and 0xF produce `imm_out` = 0, whether or not a prefix is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode consumes `ir` at this clock edge |
| annul | input | 1 | Instruction in `ir` is squashed |
| ir | input | 16 | Instruction register; opcode in bits 15:12 |
| imm_out | output | 16 | Immediate operand for the current instruction |
| prefix_pending | output | 1 | A prefix field is waiting for its consumer |
| int_inhibit | output | 1 | Interrupt insertion must not happen now |
| call_target | output | 16 | Absolute call target from `ir[11:0]` |

## Verification
The critical overlap is a cycle in which the stored prefix is being consumed while a new prefix, or an annulled instruction, sits in decode. In that cycle the operand must still use the old field, and the state update must follow the new instruction. The bench drives back-to-back prefixes, prefixes with annulled consumers, and stalls between a prefix and its consumer. It also drives long random streams in which annul, stall and the opcode vary independently. A behavioural model, updated at every clock edge, supplies the expected operand, flag, inhibit and call target, and these are compared in every cycle.

// File: rtl/imm_pkg.sv
package imm_pkg;

    localparam int INSN_W     = 16;
    localparam int OPC_W      = 4;
    localparam int SHORT_W    = 4;
    localparam int PREFIX_W   = INSN_W - SHORT_W;
    localparam int CALL_SHIFT = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_ADDI = 4'h2, OP_RR   = 4'h3,
        OP_RI   = 4'h4, OP_LW   = 4'h5, OP_LB   = 4'h6, OP_RSV7 = 4'h7,
        OP_SW   = 4'h8, OP_SB   = 4'h9, OP_JAL  = 4'hA, OP_BR   = 4'hB,
        OP_CALL = 4'hC, OP_PFX  = 4'hD, OP_RSVE = 4'hE, OP_RSVF = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        EXT_NONE = 2'd0,
        EXT_SIGN = 2'd1,
        EXT_ZERO = 2'd2
    } ext_e;

    typedef struct packed {
        ext_e ext;
        logic is_prefix;
        logic is_call;
    } dec_s;

    function automatic dec_s classify(input opcode_e opc);
        dec_s d;
        d.ext       = EXT_NONE;
        d.is_prefix = 1'b0;
        d.is_call   = 1'b0;
        case (opc)
            OP_ADDI, OP_LW, OP_LB, OP_SW, OP_SB, OP_JAL: d.ext = EXT_SIGN;
            OP_RI:   d.ext       = EXT_ZERO;
            OP_PFX:  d.is_prefix = 1'b1;
            OP_CALL: d.is_call   = 1'b1;
            default: d.ext       = EXT_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/imm_decode.sv
module imm_decode
    import imm_pkg::*;
#(
    parameter int IW = INSN_W,
    parameter int OW = OPC_W,
    parameter int SW = SHORT_W
) (
    input  logic [IW-1:0]    ir,
    output dec_s             dec,
    output logic [IW-OW-1:0] long_field,
    output logic [SW-1:0]    short_field
);
    always_comb begin
        dec         = classify(opcode_e'(ir[IW-1 -: OW]));
        long_field  = ir[IW-OW-1:0];
        short_field = ir[SW-1:0];
    end
endmodule

// File: rtl/imm_prefix_state.sv
module imm_prefix_state #(
    parameter int PW = imm_pkg::PREFIX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    input  logic          is_prefix,
    input  logic [PW-1:0] field_in,
    output logic          pending,
    output logic [PW-1:0] field_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            field_q <= '0;
        end else if (advance) begin
            pending <= is_prefix;
            if (is_prefix) begin
                field_q <= field_in;
            end
        end
    end
endmodule

// File: rtl/imm_assemble.sv
module imm_assemble
    import imm_pkg::*;
#(
    parameter int DW = INSN_W,
    parameter int SW = SHORT_W
) (
    input  ext_e             ext,
    input  logic             pending,
    input  logic [DW-SW-1:0] upper,
    input  logic [SW-1:0]    short_field,
    output logic [DW-1:0]    imm
);
    localparam int UW = DW - SW;

    always_comb begin
        case (ext)
            EXT_SIGN: imm = pending ? {upper, short_field}
                                    : {{UW{short_field[SW-1]}}, short_field};
            EXT_ZERO: imm = pending ? {upper, short_field}
                                    : {{UW{1'b0}}, short_field};
            default:  imm = '0;
        endcase
    end
endmodule

// File: rtl/imm_prefix_gen.sv
module imm_prefix_gen
    import imm_pkg::*;
#(
    parameter int IW  = INSN_W,
    parameter int SW  = SHORT_W,
    parameter int CSH = CALL_SHIFT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dec_valid,
    input  logic          annul,
    input  logic [IW-1:0] ir,
    output logic [IW-1:0] imm_out,
    output logic          prefix_pending,
    output logic          int_inhibit,
    output logic [IW-1:0] call_target
);
    localparam int FW = IW - OPC_W;
    localparam int PW = IW - SW;

    dec_s          dec;
    logic [FW-1:0] long_field;
    logic [SW-1:0] short_field;
    logic [PW-1:0] stored;
    logic          advance;

    imm_decode #(.IW(IW), .OW(OPC_W), .SW(SW)) u_dec (
        .ir          (ir),
        .dec         (dec),
        .long_field  (long_field),
        .short_field (short_field)
    );

    assign advance = dec_valid && !annul;

    imm_prefix_state #(.PW(PW)) u_state (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .is_prefix (dec.is_prefix),
        .field_in  (long_field[PW-1:0]),
        .pending   (prefix_pending),
        .field_q   (stored)
    );

    imm_assemble #(.DW(IW), .SW(SW)) u_asm (
        .ext         (dec.ext),
        .pending     (prefix_pending),
        .upper       (stored),
        .short_field (short_field),
        .imm         (imm_out)
    );

    assign int_inhibit = prefix_pending || (advance && dec.is_prefix);

    generate
        if (FW + CSH >= IW) begin : g_call_trunc
            assign call_target = {long_field[IW-CSH-1:0], {CSH{1'b0}}};
        end else begin : g_call_pad
            assign call_target = {{(IW-FW-CSH){1'b0}}, long_field, {CSH{1'b0}}};
        end
    endgenerate
endmodule

// File: rtl/imm_prefix_chk.sv
module imm_prefix_chk (
    input logic        clk,
    input logic        rst,
    input logic        dec_valid,
    input logic        annul,
    input logic [15:0] ir,
    input logic [15:0] imm_out,
    input logic        prefix_pending,
    input logic        int_inhibit,
    input logic [15:0] call_target
);
    logic [3:0] opc;
    assign opc = ir[15:12];

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> !prefix_pending);

    // R4
    prefix_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !annul && opc == 4'hD) |=> prefix_pending);

    // R6
    consume_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !annul && opc != 4'hD) |=> !prefix_pending);

    // R7
    annul_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && annul) |=> $stable(prefix_pending));

    // R8
    stall_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |=> $stable(prefix_pending));

    // R9
    inhibit_cover_chk: assert property (@(posedge clk) disable iff (rst)
        prefix_pending |-> int_inhibit);

    // R5
    low_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        (prefix_pending && opc == 4'h2) |-> imm_out[3:0] == ir[3:0]);

    // R11
    no_imm_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == 4'hB || opc == 4'hE || opc == 4'hF) |-> imm_out == 16'h0000);

    // R10
    call_align_chk: assert property (@(posedge clk) disable iff (rst)
        call_target[3:0] == 4'h0);
endmodule

bind imm_prefix_gen imm_prefix_chk i_chk (
    .clk            (clk),
    .rst            (rst),
    .dec_valid      (dec_valid),
    .annul          (annul),
    .ir             (ir),
    .imm_out        (imm_out),
    .prefix_pending (prefix_pending),
    .int_inhibit    (int_inhibit),
    .call_target    (call_target)
);

// File: tb/test_imm_prefix_gen.sv
`timescale 1ns/1ps
module test_imm_prefix_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dec_valid = 1'b0;
    logic        annul = 1'b0;
    logic [15:0] ir = 16'h0000;
    logic [15:0] imm_out;
    logic        prefix_pending;
    logic        int_inhibit;
    logic [15:0] call_target;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    bit        m_pend = 1'b0;
    bit [11:0] m_field = 12'h000;

    always #5 clk = ~clk;

    imm_prefix_gen i_imm_prefix_gen (
        .clk            (clk),
        .rst            (rst),
        .dec_valid      (dec_valid),
        .annul          (annul),
        .ir             (ir),
        .imm_out        (imm_out),
        .prefix_pending (prefix_pending),
        .int_inhibit    (int_inhibit),
        .call_target    (call_target)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_imm(input logic [15:0] insn);
        logic [3:0] op;
        op = insn[15:12];
        if (op inside {4'h2, 4'h5, 4'h6, 4'h8, 4'h9, 4'hA, 4'h4}) begin
            if (m_pend) return {m_field, insn[3:0]};
            if (op == 4'h4) return {12'h000, insn[3:0]};
            return {{12{insn[3]}}, insn[3:0]};
        end
        return 16'h0000;
    endfunction

    function automatic string imm_tag(input logic [15:0] insn);
        logic [3:0] op;
        op = insn[15:12];
        if (!(op inside {4'h2, 4'h5, 4'h6, 4'h8, 4'h9, 4'hA, 4'h4})) return "R11";
        if (m_pend) return "R5";
        if (op == 4'h4) return "R3";
        return "R2";
    endfunction

    // Drives one cycle, checks the combinational outputs, then advances the model.
    task automatic step(input bit v, input bit an, input logic [15:0] insn,
                        input string state_tag);
        bit inh;
        @(negedge clk);
        dec_valid = v;
        annul     = an;
        ir        = insn;
        #1;
        check(state_tag, "prefix_pending", {15'b0, prefix_pending}, {15'b0, m_pend});
        check(imm_tag(insn), "imm_out", imm_out, ref_imm(insn));
        inh = m_pend || (v && !an && insn[15:12] == 4'hD);
        check("R9", "int_inhibit", {15'b0, int_inhibit}, {15'b0, inh});
        check("R10", "call_target", call_target, {insn[11:0], 4'h0});
        @(posedge clk);
        if (v && !an) begin
            m_pend = (insn[15:12] == 4'hD);
            if (insn[15:12] == 4'hD) m_field = insn[11:0];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pend = 1'b0;
        // R1: reset state
        step(1'b1, 1'b0, 16'h231F, "R1");
        // R2: sign extension without prefix
        step(1'b1, 1'b0, 16'h5127, "R2");
        step(1'b1, 1'b0, 16'hA0F8, "R2");
        // R3: zero extension of logic immediates
        step(1'b1, 1'b0, 16'h412F, "R3");
        // R4 then R5 and R6
        step(1'b1, 1'b0, 16'hDABC, "R4");
        step(1'b1, 1'b0, 16'h2125, "R4");
        step(1'b1, 1'b0, 16'h2129, "R6");
        // R5 with a zero-extending consumer
        step(1'b1, 1'b0, 16'hD123, "R4");
        step(1'b1, 1'b0, 16'h4E1F, "R5");
        // R8: stall between prefix and consumer
        step(1'b1, 1'b0, 16'hD5A5, "R4");
        step(1'b0, 1'b0, 16'h0000, "R8");
        step(1'b0, 1'b0, 16'hDFFF, "R8");
        step(1'b0, 1'b1, 16'h3000, "R8");
        step(1'b1, 1'b0, 16'h8347, "R8");
        // R7: annulled prefix neither sets nor stores
        step(1'b1, 1'b1, 16'hD777, "R7");
        step(1'b1, 1'b0, 16'h2008, "R7");
        // R7: annulled consumer does not clear
        step(1'b1, 1'b0, 16'hD246, "R4");
        step(1'b1, 1'b1, 16'h2003, "R7");
        step(1'b1, 1'b0, 16'h9003, "R7");
        // R6: prefix after prefix replaces field
        step(1'b1, 1'b0, 16'hD111, "R4");
        step(1'b1, 1'b0, 16'hD999, "R6");
        step(1'b1, 1'b0, 16'h6001, "R6");
        // R11 and R10: non-immediate opcodes while pending, call target
        step(1'b1, 1'b0, 16'hD0F0, "R4");
        step(1'b1, 1'b0, 16'hC123, "R11");
        step(1'b1, 1'b0, 16'hB0FF, "R11");
        step(1'b1, 1'b0, 16'hEFFF, "R11");
        step(1'b1, 1'b0, 16'hF00F, "R11");
        step(1'b1, 1'b0, 16'h7FFF, "R11");
        // random mix
        for (int k = 0; k < 2000; k++) begin
            logic [15:0] rnd;
            rnd = 16'($urandom);
            if (($urandom % 4) == 0) rnd[15:12] = 4'hD;
            step(($urandom % 5) != 0, ($urandom % 6) == 0, rnd, "R6");
        end
        // R1: reset mid-prefix
        step(1'b1, 1'b0, 16'hDCCC, "R4");
        @(negedge clk);
        rst = 1'b1;
        dec_valid = 1'b0;
        @(posedge clk);
        m_pend = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, 1'b0, 16'h2008, "R1");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule